// File: doc/BRIEF.md
# SPI flash command front-end

This block is the slave-side command interpreter of a serial flash device. It watches the SPI pins and shifts in a one-byte opcode, MSB first, on rising SCLK edges. It then counts the address, dummy or data bytes that follow. When chip select returns high, it decides whether the command is accepted or rejected. It keeps a small status register holding a write-enable latch, three block-protect bits and a status-register-protect bit. It answers a status read by shifting that register out on SO.

The block runs entirely in a system clock domain. SCLK, CS#, SI and WP# are brought in through a synchroniser chain and their edges are detected on `clk`. The SPI clock must therefore be several times slower than `clk`. Each command produces exactly one single-cycle strobe, either accept or reject, a few clock cycles after CS# rises. Downstream array logic uses that strobe together with the reported opcode. A command that is rejected changes no state.

Top module: `sflash_cmd_front`

## Requirements
- R1: After reset the status byte reads 00h, SO is not enabled and neither strobe is asserted.
- R2: The opcode is the first 8 bits shifted in on SI, MSB first. On each accept strobe, `cmd_opcode` equals that opcode.
- R3: Opcode 06h, when accepted, sets the write-enable latch (status bit 1). Opcode 04h, when accepted, clears it.
- R4: After opcode 05h, SO presents the status byte MSB first, one bit per SCLK falling edge, and repeats it every 8 clocks. The status byte layout is: bit 7 protect, bits 4..2 block protect, bit 1 write-enable latch, bits 6, 5 and 0 read as 0.
- R5: `so_oe` is low while CS# is high and during the opcode. It is high only in the data-out phase of opcode 05h.
- R6: The command-only and write-class opcodes 06h, 04h, B9h, C7h, 60h, 02h, 20h, D8h and 01h are rejected, with no state change, if the SCLK count at CS# rising is not a multiple of 8.
- R7: The read-class opcodes 03h, 0Bh, ABh, 9Fh, 90h and 05h are accepted whenever CS# rises after the opcode is complete, whatever the bit count.
- R8: Opcode 01h with the latch set and protect bit 0 copies data-byte bits 7 and 4..2 into the status register and clears the latch, at either level of WP#.
- R9: With the protect bit at 1 and WP# low, opcode 01h is rejected and the status register is unchanged.
- R10: With the protect bit at 1 and WP# high, opcode 01h is accepted when the latch is set.
- R11: Opcodes 02h, 20h, D8h, C7h, 60h and 01h are rejected while the latch is clear. When accepted they clear the latch. A partial-byte 02h leaves the latch set.
- R12: Commands that are too short are rejected: 01h needs at least 2 bytes, 20h and D8h at least 4, and 02h at least 5.
- R13: An unknown opcode or an incomplete opcode gives a reject strobe and no state change. A CS# pulse with no SCLK edges gives no strobe.
- R14: Each CS# window yields at most one strobe. The strobe lasts one clock, and accept and reject are never asserted together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | SPI serial clock (asynchronous) |
| cs_n | input | 1 | Chip select, active low |
| si | input | 1 | Serial data in |
| wp_n | input | 1 | Hardware write-protect, active low |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for SO (tri-state control) |
| cmd_accept | output | 1 | One-cycle strobe: command accepted |
| cmd_reject | output | 1 | One-cycle strobe: command rejected |
| cmd_opcode | output | 8 | Opcode of the most recently decided command |

## Verification
The hardest condition to reach is a status write while the protect bit is 1. It needs three steps: first a status write with WP# high sets the protect bit, then the latch is set or cleared, and only then is WP# lowered before the write under test. The bench therefore walks a scripted sequence over every combination of protect bit, WP# level and latch state. It also sweeps every known opcode, plus unknown ones, across aligned, misaligned and short bit counts. A bench-side model of the status register predicts each strobe. The status is read back over SO after every case.

// File: rtl/sflash_pkg.sv
`timescale 1ns/1ps
package sflash_pkg;

  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_PROG = 8'h02;
  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_FRD  = 8'h0B;
  localparam logic [7:0] OP_SERS = 8'h20;
  localparam logic [7:0] OP_CER1 = 8'h60;
  localparam logic [7:0] OP_RID1 = 8'h90;
  localparam logic [7:0] OP_RID2 = 8'h9F;
  localparam logic [7:0] OP_WAKE = 8'hAB;
  localparam logic [7:0] OP_SLP  = 8'hB9;
  localparam logic [7:0] OP_CER2 = 8'hC7;
  localparam logic [7:0] OP_BERS = 8'hD8;

  localparam int ST_PROT = 7;
  localparam int ST_WEL  = 1;
  localparam logic [7:0] ST_WR_MASK = 8'b1001_1100;

  typedef enum logic [2:0] {
    CL_NONE, CL_READ, CL_WREN, CL_WRDI, CL_WRSR, CL_MODIFY, CL_SLEEP
  } cmd_cls_e;

  typedef struct packed {
    cmd_cls_e   cls;
    logic       needs_wel;
    logic [3:0] min_bytes;
  } op_info_t;

  function automatic op_info_t classify(input logic [7:0] op);
    op_info_t r;
    r.cls       = CL_NONE;
    r.needs_wel = 1'b0;
    r.min_bytes = 4'd1;
    case (op)
      OP_READ, OP_FRD, OP_WAKE, OP_RID1, OP_RID2, OP_RDSR: r.cls = CL_READ;
      OP_WREN: r.cls = CL_WREN;
      OP_WRDI: r.cls = CL_WRDI;
      OP_SLP:  r.cls = CL_SLEEP;
      OP_WRSR: begin r.cls = CL_WRSR;   r.needs_wel = 1'b1; r.min_bytes = 4'd2; end
      OP_PROG: begin r.cls = CL_MODIFY; r.needs_wel = 1'b1; r.min_bytes = 4'd5; end
      OP_SERS, OP_BERS: begin r.cls = CL_MODIFY; r.needs_wel = 1'b1; r.min_bytes = 4'd4; end
      OP_CER1, OP_CER2: begin r.cls = CL_MODIFY; r.needs_wel = 1'b1; r.min_bytes = 4'd1; end
      default: r.cls = CL_NONE;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/sflash_sync.sv
`timescale 1ns/1ps
module sflash_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= RST_VAL;
        else     stg[g] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= RST_VAL;
        else     stg[g] <= stg[g-1];
      end
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/sflash_rx.sv
`timescale 1ns/1ps
module sflash_rx #(
  parameter int MAX_BYTES = 8,
  localparam int BC_W = $clog2(MAX_BYTES + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cs_s,
  input  logic            sclk_rise,
  input  logic            si_s,
  output logic [2:0]      bit_idx,
  output logic [BC_W-1:0] byte_cnt,
  output logic [7:0]      opcode,
  output logic [7:0]      data1
);
  logic [6:0] shreg;
  logic [7:0] next_byte;

  assign next_byte = {shreg, si_s};

  always_ff @(posedge clk) begin
    if (rst || cs_s) begin
      shreg    <= '0;
      bit_idx  <= '0;
      byte_cnt <= '0;
      opcode   <= '0;
      data1    <= '0;
    end else if (sclk_rise) begin
      shreg   <= next_byte[6:0];
      bit_idx <= bit_idx + 3'd1;
      if (bit_idx == 3'd7) begin
        if (byte_cnt != BC_W'(MAX_BYTES)) byte_cnt <= byte_cnt + BC_W'(1);
        if (byte_cnt == BC_W'(0)) opcode <= next_byte;
        if (byte_cnt == BC_W'(1)) data1  <= next_byte;
      end
    end
  end
endmodule

// File: rtl/sflash_judge.sv
`timescale 1ns/1ps
module sflash_judge #(
  parameter int MAX_BYTES = 8,
  localparam int BC_W = $clog2(MAX_BYTES + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cs_rise,
  input  logic            wp_s,
  input  logic [2:0]      bit_idx,
  input  logic [BC_W-1:0] byte_cnt,
  input  logic [7:0]      opcode,
  input  logic [7:0]      data1,
  output logic [7:0]      status,
  output logic            accept,
  output logic            reject,
  output logic [7:0]      op_out
);
  import sflash_pkg::*;

  op_info_t info;
  logic     op_done, silent, aligned, long_enough, wel_ok, locked, go;

  always_comb begin
    info        = classify(opcode);
    op_done     = byte_cnt != BC_W'(0);
    silent      = !op_done && bit_idx == 3'd0;
    aligned     = bit_idx == 3'd0;
    long_enough = int'(byte_cnt) >= int'(info.min_bytes);
    wel_ok      = !info.needs_wel || status[ST_WEL];
    locked      = info.cls == CL_WRSR && status[ST_PROT] && !wp_s;
    if (!op_done)                 go = 1'b0;
    else if (info.cls == CL_READ) go = 1'b1;
    else if (info.cls == CL_NONE) go = 1'b0;
    else                          go = aligned && long_enough && wel_ok && !locked;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      accept <= 1'b0;
      reject <= 1'b0;
      op_out <= '0;
    end else begin
      accept <= 1'b0;
      reject <= 1'b0;
      if (cs_rise && !silent) begin
        op_out <= opcode;
        if (go) begin
          accept <= 1'b1;
          case (info.cls)
            CL_WREN:   status[ST_WEL] <= 1'b1;
            CL_WRDI:   status[ST_WEL] <= 1'b0;
            CL_MODIFY: status[ST_WEL] <= 1'b0;
            CL_WRSR:   status <= data1 & ST_WR_MASK;
            default:   status <= status;
          endcase
        end else begin
          reject <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sflash_tx.sv
`timescale 1ns/1ps
module sflash_tx (
  input  logic       clk,
  input  logic       rst,
  input  logic       cs_s,
  input  logic       sclk_fall,
  input  logic       rdsr_active,
  input  logic [7:0] status,
  output logic       so,
  output logic       so_oe
);
  logic [2:0] idx;

  always_ff @(posedge clk) begin
    if (rst || cs_s) begin
      so    <= 1'b0;
      so_oe <= 1'b0;
      idx   <= 3'd7;
    end else if (rdsr_active && sclk_fall) begin
      so    <= status[idx];
      so_oe <= 1'b1;
      idx   <= idx - 3'd1;
    end
  end
endmodule

// File: rtl/sflash_cmd_front.sv
`timescale 1ns/1ps
module sflash_cmd_front #(
  parameter int SYNC_STAGES = 2,
  parameter int MAX_BYTES   = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sclk,
  input  logic       cs_n,
  input  logic       si,
  input  logic       wp_n,
  output logic       so,
  output logic       so_oe,
  output logic       cmd_accept,
  output logic       cmd_reject,
  output logic [7:0] cmd_opcode
);
  import sflash_pkg::*;
  localparam int BC_W = $clog2(MAX_BYTES + 1);

  logic [3:0]      pins_s;
  logic            sclk_s, cs_s, si_s, wp_s;
  logic            sclk_q, cs_q;
  logic            sclk_rise, sclk_fall, cs_rise;
  logic [2:0]      bit_idx;
  logic [BC_W-1:0] byte_cnt;
  logic [7:0]      opcode, data1, status;
  logic            rdsr_active;

  sflash_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1010)) u_sync (
    .clk(clk), .rst(rst), .din({wp_n, si, cs_n, sclk}), .dout(pins_s)
  );

  assign {wp_s, si_s, cs_s, sclk_s} = pins_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
    end else begin
      sclk_q <= sclk_s;
      cs_q   <= cs_s;
    end
  end

  assign sclk_rise = sclk_s && !sclk_q && !cs_s;
  assign sclk_fall = !sclk_s && sclk_q && !cs_s;
  assign cs_rise   = cs_s && !cs_q;

  sflash_rx #(.MAX_BYTES(MAX_BYTES)) u_rx (
    .clk(clk), .rst(rst), .cs_s(cs_s), .sclk_rise(sclk_rise), .si_s(si_s),
    .bit_idx(bit_idx), .byte_cnt(byte_cnt), .opcode(opcode), .data1(data1)
  );

  sflash_judge #(.MAX_BYTES(MAX_BYTES)) u_judge (
    .clk(clk), .rst(rst), .cs_rise(cs_rise), .wp_s(wp_s),
    .bit_idx(bit_idx), .byte_cnt(byte_cnt), .opcode(opcode), .data1(data1),
    .status(status), .accept(cmd_accept), .reject(cmd_reject), .op_out(cmd_opcode)
  );

  assign rdsr_active = byte_cnt != BC_W'(0) && opcode == OP_RDSR;

  sflash_tx u_tx (
    .clk(clk), .rst(rst), .cs_s(cs_s), .sclk_fall(sclk_fall),
    .rdsr_active(rdsr_active), .status(status), .so(so), .so_oe(so_oe)
  );
endmodule

// File: rtl/sflash_cmd_front_chk.sv
`timescale 1ns/1ps
module sflash_cmd_front_chk (
  input logic       clk,
  input logic       rst,
  input logic       cs_s,
  input logic       wp_s,
  input logic [7:0] status,
  input logic       so_oe,
  input logic       cmd_accept,
  input logic       cmd_reject,
  input logic [7:0] cmd_opcode
);
  import sflash_pkg::*;

  p_strobe_excl_r14: assert property (@(posedge clk) disable iff (rst)
    !(cmd_accept && cmd_reject));

  p_strobe_pulse_r14: assert property (@(posedge clk) disable iff (rst)
    (cmd_accept || cmd_reject) |=> !(cmd_accept || cmd_reject));

  p_so_idle_r5: assert property (@(posedge clk) disable iff (rst)
    cs_s |=> !so_oe);

  p_quiet_reject_r13: assert property (@(posedge clk) disable iff (rst)
    cmd_reject |-> $stable(status));

  p_change_needs_accept_r6: assert property (@(posedge clk) disable iff (rst)
    !$stable(status) |-> cmd_accept);

  p_wrsr_lock_r9: assert property (@(posedge clk) disable iff (rst)
    (cmd_accept && cmd_opcode == OP_WRSR) |-> $past(!status[ST_PROT] || wp_s));

  p_wren_sets_r3: assert property (@(posedge clk) disable iff (rst)
    (cmd_accept && cmd_opcode == OP_WREN) |-> status[ST_WEL]);

  p_prog_clears_r11: assert property (@(posedge clk) disable iff (rst)
    (cmd_accept && cmd_opcode == OP_PROG) |-> !status[ST_WEL]);

  p_modify_needs_wel_r11: assert property (@(posedge clk) disable iff (rst)
    (cmd_accept && cmd_opcode == OP_PROG) |-> $past(status[ST_WEL]));
endmodule

bind sflash_cmd_front sflash_cmd_front_chk u_chk (
  .clk(clk), .rst(rst), .cs_s(cs_s), .wp_s(wp_s), .status(status),
  .so_oe(so_oe), .cmd_accept(cmd_accept), .cmd_reject(cmd_reject),
  .cmd_opcode(cmd_opcode)
);

// File: tb/test_sflash_cmd_front.sv
`timescale 1ns/1ps
module test_sflash_cmd_front;
  localparam int HALF = 5;

  logic clk = 1'b0, rst = 1'b1, sclk = 1'b0, cs_n = 1'b1, si = 1'b0, wp_n = 1'b1;
  logic so, so_oe, cmd_accept, cmd_reject;
  logic [7:0] cmd_opcode;

  int n_chk = 0, n_fail = 0, n_acc = 0, n_rej = 0;
  logic [7:0] last_op = '0;
  logic [71:0] got, got_oe;
  bit m_prot = 0, m_wel = 0;
  logic [2:0] m_bp = '0;

  always #2.5 clk = ~clk;

  sflash_cmd_front i_sflash_cmd_front (
    .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .si(si), .wp_n(wp_n),
    .so(so), .so_oe(so_oe), .cmd_accept(cmd_accept), .cmd_reject(cmd_reject),
    .cmd_opcode(cmd_opcode)
  );

  always @(negedge clk) begin
    if (cmd_accept) begin n_acc = n_acc + 1; last_op = cmd_opcode; end
    if (cmd_reject) n_rej = n_rej + 1;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] model_byte();
    return {m_prot, 2'b00, m_bp, m_wel, 1'b0};
  endfunction

  function automatic bit exp_go(input logic [7:0] op, input int nb);
    int nby;
    bit al;
    nby = nb / 8;
    al  = (nb % 8) == 0;
    if (nb < 8) return 0;
    case (op)
      8'h03, 8'h0B, 8'hAB, 8'h9F, 8'h90, 8'h05: return 1;
      8'h06, 8'h04, 8'hB9: return al;
      8'hC7, 8'h60: return al && m_wel;
      8'h02: return al && m_wel && nby >= 5;
      8'h20, 8'hD8: return al && m_wel && nby >= 4;
      8'h01: return al && m_wel && nby >= 2 && !(m_prot && !wp_n);
      default: return 0;
    endcase
  endfunction

  task automatic xact(input logic [71:0] v, input int nb);
    got = '0; got_oe = '0;
    cs_n = 1'b0;
    tick(HALF);
    for (int i = 0; i < nb; i++) begin
      si = v[71-i];
      tick(HALF);
      got[71-i] = so;
      got_oe[71-i] = so_oe;
      sclk = 1'b1;
      tick(HALF);
      sclk = 1'b0;
    end
    tick(HALF);
    cs_n = 1'b1;
    tick(8);
  endtask

  task automatic read_status(output logic [7:0] s);
    xact({8'h05, 64'h0}, 24);
    s = got[63:56];
    check(got[55:48] == got[63:56], "R4 repeat", got[55:48], got[63:56]);
    check(got_oe[71:64] == 8'h00 && got_oe[63:48] == 16'hFFFF, "R5 oe", got_oe[71:48], 24'h00FFFF);
  endtask

  task automatic apply(input logic [7:0] op, input int nb, input logic [63:0] pay, input bit verify);
    int a0, r0;
    bit g;
    string tag;
    logic [7:0] s;
    a0 = n_acc; r0 = n_rej;
    g = exp_go(op, nb);
    if (nb < 8) tag = "R13";
    else if (op == 8'h03 || op == 8'h0B || op == 8'hAB || op == 8'h9F || op == 8'h90 || op == 8'h05) tag = "R7";
    else if (nb % 8 != 0) tag = "R6";
    else if (op == 8'h06 || op == 8'h04) tag = "R3";
    else if (op == 8'h01) tag = (m_prot && !wp_n) ? "R9" : (m_prot ? "R10" : "R8");
    else if (op == 8'h02 || op == 8'h20 || op == 8'hD8) tag = "R12";
    else if (op == 8'hC7 || op == 8'h60) tag = "R11";
    else if (op == 8'hB9) tag = "R6";
    else tag = "R13";
    xact({op, pay}, nb);
    if (nb == 0)
      check(n_acc == a0 && n_rej == r0, "R13 silent", n_acc + n_rej - a0 - r0, 0);
    else begin
      check((n_acc - a0) == (g ? 1 : 0), {tag, " accept"}, n_acc - a0, g ? 1 : 0);
      check((n_rej - r0) == (g ? 0 : 1), "R14 one strobe", n_rej - r0, g ? 0 : 1);
    end
    if (g) begin
      check(last_op == op, "R2 opcode", last_op, op);
      case (op)
        8'h06: m_wel = 1;
        8'h04: m_wel = 0;
        8'h02, 8'h20, 8'hD8, 8'hC7, 8'h60: m_wel = 0;
        8'h01: begin m_prot = pay[63]; m_bp = pay[60:58]; m_wel = 0; end
        default: ;
      endcase
    end
    if (verify) begin
      read_status(s);
      check(s == model_byte(), {tag, " status"}, s, model_byte());
    end
  endtask

  localparam logic [7:0] OPS [17] = '{8'h06, 8'h04, 8'h02, 8'h20, 8'hD8, 8'hC7, 8'h60, 8'hB9,
                                      8'h01, 8'h03, 8'h0B, 8'hAB, 8'h9F, 8'h90, 8'h05, 8'hFF, 8'h00};
  localparam int LENS [5] = '{8, 13, 16, 32, 40};

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R14 actual=%0h expected=%0h", 1, 0);
    finish_run();
  end

  initial begin
    logic [7:0] s;
    tick(4);
    rst = 1'b0;
    tick(4);
    check(so_oe == 1'b0, "R1 oe", so_oe, 0);
    check(cmd_accept == 1'b0 && cmd_reject == 1'b0, "R1 strobes", {cmd_accept, cmd_reject}, 0);
    check(n_acc == 0 && n_rej == 0, "R1 quiet", n_acc + n_rej, 0);
    read_status(s);
    check(s == 8'h00, "R1 status", s, 0);

    apply(8'h06, 0, 64'h0, 1'b0);
    apply(8'h06, 5, 64'h0, 1'b1);

    m_wel = m_wel;
    apply(8'h06, 8, 64'h0, 1'b1);
    apply(8'h02, 44, 64'h0, 1'b1);
    check(m_wel == 1'b1, "R11 partial keeps latch", m_wel, 1);

    for (int o = 0; o < 17; o++) begin
      for (int l = 0; l < 5; l++) begin
        for (int w = 0; w < 2; w++) begin
          logic [63:0] pay;
          pay = {8'(o * 29 + l * 7 + w) & 8'h1C, 56'h5A_3C_96_0F_E1_77_88};
          apply(w ? 8'h06 : 8'h04, 8, 64'h0, 1'b0);
          apply(OPS[o], LENS[l], pay, 1'b1);
          check(so_oe == 1'b0, "R5 idle", so_oe, 0);
        end
      end
    end

    for (int p = 0; p < 2; p++) begin
      for (int wp = 0; wp < 2; wp++) begin
        for (int w = 0; w < 2; w++) begin
          wp_n = 1'b1;
          apply(8'h06, 8, 64'h0, 1'b0);
          apply(8'h01, 16, {p[0], 7'b0001100, 56'h0}, 1'b1);
          apply(w ? 8'h06 : 8'h04, 8, 64'h0, 1'b0);
          wp_n = wp[0];
          apply(8'h01, 16, {8'h10, 56'h0}, 1'b1);
          wp_n = 1'b1;
        end
      end
    end

    wp_n = 1'b1;
    apply(8'h06, 8, 64'h0, 1'b0);
    apply(8'h01, 16, 64'h0, 1'b1);
    finish_run();
  end
endmodule